// File: doc/BRIEF.md
# Strobe-Driven Multi-Queue Read Port

This block is the device-side read port of a set of small byte queues that an external master drains using asynchronous, active-low control strobes. The master places a queue number on a select input, asserts a chip select, opens the output enable to let the port drive a shared bidirectional data bus, and pulses a read strobe once per byte. All external controls are brought into the internal clock domain through a multi-flop synchronizer before the port acts on them, so the strobe timing the master must respect is counted in internal clock cycles.

The output enable alone decides whether the bus is driven. While driven, the bus shows the byte at the head of the selected queue. A qualified read (chip select and read strobe both asserted) does not change the bus while it is held. The queue advances when that strobe is released, and the next byte appears afterwards. A bursty master pulses the strobe repeatedly and collects consecutive entries. Each queue has its own empty and full flag. A simple write port on the device side fills the queues.

Top module: `sfrp_read_port`

## Requirements
- R1: After reset every queue reports empty (all `empty_o` bits 1), none reports full, and `bus_drive_o` is 0.
- R2: While `ext_oe_n` is high (deasserted) the port does not drive `data_io` (`bus_drive_o` is 0), whatever the other strobes do.
- R3: With `ext_oe_n` low and no read strobe, the port drives the head byte of the queue selected by `ext_sel` and keeps showing that same byte for as long as no qualified read completes.
- R4: A read strobe counts only while `ext_cs_n` is also low. A strobe pulse with `ext_cs_n` high does not advance any queue.
- R5: The queue advances on the release (low-to-high) of a qualified read strobe. While the strobe is held, the bus still shows the byte from before the read, and after the release it shows the next entry.
- R6: Successive qualified strobe pulses return entries N, N+1, N+2 in write order, also when `ext_oe_n` and `ext_rd_n` are driven together.
- R7: The empty flag of a queue rises on the third rising clock edge after the release of the strobe that removes its last entry (two synchronizer edges, then the pointer update), and not before.
- R8: A qualified strobe on an empty queue moves no pointer, and the bus keeps the last byte it showed.
- R9: `ext_sel` (queue number 0 to 3) picks the queue that is shown and advanced. Reads of one queue leave the contents and flags of the others unchanged, and at most one queue advances per cycle.
- R10: A queue holds 16 bytes. After 16 writes its full flag is set, a further write to it is dropped, and reading it out returns exactly the 16 written bytes before it reports empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 2 | Queue number from the master, synchronized internally |
| ext_cs_n | input | 1 | Active-low chip select |
| ext_oe_n | input | 1 | Active-low output enable for the data bus |
| ext_rd_n | input | 1 | Active-low read strobe |
| data_io | inout | 8 | Shared data bus, driven only while output is enabled |
| bus_drive_o | output | 1 | High while the port drives `data_io` (pad enable) |
| empty_o | output | 4 | Per-queue empty flags |
| full_o | output | 4 | Per-queue full flags |
| wr_en_i | input | 1 | Device-side write strobe, one byte per cycle |
| wr_sel_i | input | 2 | Queue number for the device-side write |
| wr_data_i | input | 8 | Byte to write |

## Verification
The bound checker watches, every cycle, the relations that span the synchronizer: the bus is never driven when output enable was deasserted a synchronizer latency earlier, no queue advances unless chip select was low at the matching earlier cycle, at most one queue advances at once, an empty flag rises only after an advance, a full queue stays full under writes alone, and the shown byte does not change while the selected queue is empty. Only the bench's scenarios can show which byte appears and in which order: the head byte before and during a held strobe, the next byte after its release, burst ordering with tied enables, the exact edge on which the empty flag rises, and whole-queue contents after an overfill.

// File: rtl/sfrp_pkg.sv
package sfrp_pkg;

   // Internal, active-high view of the synchronized master controls.
   typedef struct packed {
      logic cs;
      logic oe;
      logic rd;
   } strobe_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sfrp_sync.sv
module sfrp_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sfrp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sfrp_queue.sv
module sfrp_queue #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              full
);

   localparam int IDX_W = $clog2(DEPTH);
   localparam int PTR_W = IDX_W + 1;

   generate
      if (!sfrp_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("sfrp_queue: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;
   logic              do_push, do_pop;

   assign empty   = (wptr == rptr);
   assign full    = (wptr[IDX_W-1:0] == rptr[IDX_W-1:0]) &&
                    (wptr[IDX_W] != rptr[IDX_W]);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = store[rptr[IDX_W-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) store[wptr[IDX_W-1:0]] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
      end
   end

endmodule

// File: rtl/sfrp_rd_ctrl.sv
module sfrp_rd_ctrl #(
   parameter int N_Q    = 4,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              rd_act,
   input  logic [ADDR_W-1:0] sel_s,
   input  logic [N_Q-1:0]    q_empty,
   output logic [N_Q-1:0]    adv
);

   logic              qual, qual_q;
   logic [ADDR_W-1:0] sel_hold;
   logic              release_edge;

   assign qual         = cs_act && rd_act;
   assign release_edge = qual_q && !qual;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_q   <= 1'b0;
         sel_hold <= '0;
      end else begin
         qual_q <= qual;
         if (qual && !qual_q) sel_hold <= sel_s;
      end
   end

   generate
      for (genvar g = 0; g < N_Q; g++) begin : g_adv
         assign adv[g] = release_edge && (sel_hold == ADDR_W'(g)) && !q_empty[g];
      end
   endgenerate

endmodule

// File: rtl/sfrp_read_port.sv
module sfrp_read_port #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 16,
   parameter int N_Q         = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = (N_Q > 1) ? $clog2(N_Q) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_sel,
   input  logic              ext_cs_n,
   input  logic              ext_oe_n,
   input  logic              ext_rd_n,
   inout  wire  [DATA_W-1:0] data_io,
   output logic              bus_drive_o,
   output logic [N_Q-1:0]    empty_o,
   output logic [N_Q-1:0]    full_o,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i
);

   import sfrp_pkg::*;

   localparam int SYNC_W = ADDR_W + 3;
   localparam logic [SYNC_W-1:0] SYNC_RST = {{ADDR_W{1'b0}}, 3'b111};

   generate
      if (N_Q < 2 || (1 << ADDR_W) < N_Q) begin : g_bad_nq
         $error("sfrp_read_port: N_Q must be at least 2 and fit ADDR_W");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("sfrp_read_port: DATA_W must be positive");
      end
   endgenerate

   // Synchronize master-side controls together.
   logic [SYNC_W-1:0] sync_out;
   logic [ADDR_W-1:0] sel_s;
   strobe_t           strb;

   sfrp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ext_sel, ext_cs_n, ext_oe_n, ext_rd_n}),
      .q     (sync_out)
   );

   assign sel_s   = sync_out[SYNC_W-1:3];
   assign strb.cs = !sync_out[2];
   assign strb.oe = !sync_out[1];
   assign strb.rd = !sync_out[0];

   // Queue bank.
   logic [N_Q-1:0]    adv;
   logic [DATA_W-1:0] heads [N_Q];

   generate
      for (genvar g = 0; g < N_Q; g++) begin : g_q
         sfrp_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (wr_en_i && (wr_sel_i == ADDR_W'(g))),
            .push_data (wr_data_i),
            .pop       (adv[g]),
            .head      (heads[g]),
            .empty     (empty_o[g]),
            .full      (full_o[g])
         );
      end
   endgenerate

   sfrp_rd_ctrl #(.N_Q(N_Q), .ADDR_W(ADDR_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_act  (strb.cs),
      .rd_act  (strb.rd),
      .sel_s   (sel_s),
      .q_empty (empty_o),
      .adv     (adv)
   );

   // Bus output register: follows the selected head, holds while empty.
   logic [DATA_W-1:0] dout_q;
   logic              drive_q;
   logic              sel_valid;

   assign sel_valid = (32'(sel_s) < N_Q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q  <= '0;
         drive_q <= 1'b0;
      end else begin
         drive_q <= strb.oe;
         if (sel_valid && !empty_o[sel_s]) dout_q <= heads[sel_s];
      end
   end

   assign bus_drive_o = drive_q;
   assign data_io     = drive_q ? dout_q : 'z;

endmodule

// File: rtl/sfrp_read_port_chk.sv
module sfrp_read_port_chk #(
   parameter int DATA_W      = 8,
   parameter int N_Q         = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ext_cs_n,
   input logic              ext_oe_n,
   input logic              bus_drive_o,
   input logic [N_Q-1:0]    empty_o,
   input logic [N_Q-1:0]    full_o,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_sel_i,
   input logic [N_Q-1:0]    adv,
   input logic [ADDR_W-1:0] sel_s,
   input logic [DATA_W-1:0] dout_q
);

   localparam int LAT = SYNC_STAGES + 1;

   logic [3:0] warm_cnt;
   logic       warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm_cnt <= '0;
      else if (!warm)      warm_cnt <= warm_cnt + 1'b1;
   end
   assign warm = (32'(warm_cnt) > LAT);

   // R2
   drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      $past(ext_oe_n, LAT) |-> !bus_drive_o);

   // R4
   cs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      (|adv) |-> !$past(ext_cs_n, LAT));

   // R9
   single_adv_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      $onehot0(adv));

   // R8
   hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      empty_o[sel_s] |=> $stable(dout_q));

   generate
      for (genvar g = 0; g < N_Q; g++) begin : g_chk
         // R7
         empty_src_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
            $rose(empty_o[g]) |-> $past(adv[g]));

         // R10
         full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
            (full_o[g] && !adv[g]) |=> full_o[g]);

         // R10
         no_wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
            (full_o[g] && wr_en_i && (wr_sel_i == ADDR_W'(g))) |=> !empty_o[g]);
      end
   endgenerate

endmodule

bind sfrp_read_port sfrp_read_port_chk #(
   .DATA_W(DATA_W), .N_Q(N_Q), .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_cs_n    (ext_cs_n),
   .ext_oe_n    (ext_oe_n),
   .bus_drive_o (bus_drive_o),
   .empty_o     (empty_o),
   .full_o      (full_o),
   .wr_en_i     (wr_en_i),
   .wr_sel_i    (wr_sel_i),
   .adv         (adv),
   .sel_s       (sel_s),
   .dout_q      (dout_q)
);

// File: tb/tb_sfrp_read_port.sv
module tb_sfrp_read_port;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ext_sel = 2'd0;
   logic       ext_cs_n = 1'b1;
   logic       ext_oe_n = 1'b1;
   logic       ext_rd_n = 1'b1;
   wire  [7:0] data_io;
   logic       bus_drive_o;
   logic [3:0] empty_o;
   logic [3:0] full_o;
   logic       wr_en_i = 1'b0;
   logic [1:0] wr_sel_i = 2'd0;
   logic [7:0] wr_data_i = 8'd0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfrp_read_port dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_sel     (ext_sel),
      .ext_cs_n    (ext_cs_n),
      .ext_oe_n    (ext_oe_n),
      .ext_rd_n    (ext_rd_n),
      .data_io     (data_io),
      .bus_drive_o (bus_drive_o),
      .empty_o     (empty_o),
      .full_o      (full_o),
      .wr_en_i     (wr_en_i),
      .wr_sel_i    (wr_sel_i),
      .wr_data_i   (wr_data_i)
   );

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
         report();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [1:0] q, input logic [7:0] v);
      @(negedge clk);
      wr_en_i   = 1'b1;
      wr_sel_i  = q;
      wr_data_i = v;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   // One qualified strobe pulse, held and released with generous spacing.
   task automatic strobe(input bit use_cs);
      @(negedge clk);
      ext_cs_n = use_cs ? 1'b0 : 1'b1;
      ext_rd_n = 1'b0;
      waitn(5);
      ext_rd_n = 1'b1;
      waitn(6);
   endtask

   task automatic t_reset();
      chk(empty_o == 4'hF, "R1 empty after reset", empty_o, 4'hF);
      chk(full_o == 4'h0, "R1 full after reset", full_o, 4'h0);
      chk(bus_drive_o == 1'b0, "R1 bus idle after reset", bus_drive_o, 0);
   endtask

   task automatic t_load();
      push(2'd1, 8'h10);
      push(2'd1, 8'h11);
      push(2'd1, 8'h12);
      push(2'd2, 8'hA0);
      waitn(2);
      chk(empty_o == 4'b1001, "R9 only written queues non-empty", empty_o, 4'b1001);
   endtask

   task automatic t_oe_off();
      @(negedge clk);
      ext_sel  = 2'd1;
      ext_oe_n = 1'b1;
      ext_cs_n = 1'b1;
      waitn(6);
      chk(bus_drive_o == 1'b0, "R2 no drive with oe high", bus_drive_o, 0);
      ext_rd_n = 1'b0;
      waitn(5);
      chk(bus_drive_o == 1'b0, "R2 no drive with rd low, oe high", bus_drive_o, 0);
      ext_rd_n = 1'b1;
      waitn(6);
   endtask

   task automatic t_oe_on();
      ext_oe_n = 1'b0;
      waitn(6);
      chk(bus_drive_o == 1'b1, "R3 drive with oe low", bus_drive_o, 1);
      chk(data_io == 8'h10, "R3 head byte shown", data_io, 8'h10);
      waitn(10);
      chk(data_io == 8'h10, "R3 head byte stable without read", data_io, 8'h10);
   endtask

   task automatic t_no_cs();
      strobe(1'b0);
      chk(data_io == 8'h10, "R4 strobe without cs ignored", data_io, 8'h10);
      chk(empty_o[1] == 1'b0, "R4 queue untouched", empty_o[1], 0);
   endtask

   task automatic t_hold_release();
      @(negedge clk);
      ext_cs_n = 1'b0;
      ext_rd_n = 1'b0;
      waitn(8);
      chk(data_io == 8'h10, "R5 bus unchanged while strobe held", data_io, 8'h10);
      ext_rd_n = 1'b1;
      waitn(6);
      chk(data_io == 8'h11, "R5 next byte after release", data_io, 8'h11);
   endtask

   task automatic t_last_and_empty();
      strobe(1'b1);
      chk(data_io == 8'h12, "R6 third byte in order", data_io, 8'h12);
      // Remove the last entry and time the empty flag.
      @(negedge clk);
      ext_rd_n = 1'b0;
      waitn(5);
      ext_rd_n = 1'b1;
      waitn(2);
      chk(empty_o[1] == 1'b0, "R7 empty not yet after two edges", empty_o[1], 0);
      waitn(1);
      chk(empty_o[1] == 1'b1, "R7 empty on third edge after release", empty_o[1], 1);
      waitn(3);
      chk(data_io == 8'h12, "R8 bus holds last byte when empty", data_io, 8'h12);
      strobe(1'b1);
      chk(data_io == 8'h12, "R8 strobe on empty keeps bus", data_io, 8'h12);
      chk(empty_o == 4'b1011, "R8 no pointer moved on empty", empty_o, 4'b1011);
      push(2'd1, 8'h55);
      waitn(3);
      chk(data_io == 8'h55, "R8 new byte after empty read, pointer intact", data_io, 8'h55);
   endtask

   task automatic t_select();
      @(negedge clk);
      ext_sel = 2'd2;
      waitn(6);
      chk(data_io == 8'hA0, "R9 selected queue shown", data_io, 8'hA0);
      chk(empty_o[2] == 1'b0, "R9 other queue unaffected", empty_o[2], 0);
      strobe(1'b1);
      chk(empty_o == 4'b1101, "R9 only selected queue drained", empty_o, 4'b1101);
   endtask

   task automatic t_burst_tied();
      for (int i = 0; i < 5; i++) push(2'd0, 8'h30 + 8'(i));
      @(negedge clk);
      ext_sel  = 2'd0;
      ext_oe_n = 1'b1;
      ext_cs_n = 1'b0;
      waitn(6);
      for (int i = 0; i < 5; i++) begin
         ext_oe_n = 1'b0;
         ext_rd_n = 1'b0;
         waitn(6);
         chk(data_io == 8'h30 + 8'(i), "R6 burst order with tied enables", data_io, 8'h30 + i);
         ext_oe_n = 1'b1;
         ext_rd_n = 1'b1;
         waitn(6);
      end
      chk(empty_o[0] == 1'b1, "R6 burst drained queue", empty_o[0], 1);
      chk(bus_drive_o == 1'b0, "R2 drive drops with oe", bus_drive_o, 0);
   endtask

   task automatic t_full();
      for (int i = 0; i < 16; i++) push(2'd3, 8'(i));
      waitn(1);
      chk(full_o[3] == 1'b1, "R10 full after 16 writes", full_o[3], 1);
      push(2'd3, 8'hEE);
      @(negedge clk);
      ext_sel  = 2'd3;
      ext_oe_n = 1'b0;
      ext_cs_n = 1'b0;
      waitn(6);
      for (int i = 0; i < 16; i++) begin
         chk(data_io == 8'(i), "R10 byte order after overfill", data_io, i);
         strobe(1'b1);
      end
      chk(empty_o[3] == 1'b1, "R10 overflow write dropped", empty_o[3], 1);
      chk(data_io == 8'h0F, "R10 last byte is sixteenth write", data_io, 8'h0F);
   endtask

   initial begin
      waitn(4);
      rst_n = 1'b1;
      waitn(2);
      t_reset();
      t_load();
      t_oe_off();
      t_oe_on();
      t_no_cs();
      t_hold_release();
      t_last_and_empty();
      t_select();
      t_burst_tied();
      t_full();
      done = 1'b1;
      report();
   end

endmodule